// File: doc/BRIEF.md
# Primary Clock Failure Monitor with Internal-Clock Fallback

The block guards the external primary device clock with a slow, always-running internal low-frequency clock. The low-frequency clock is divided down to a sample clock. In the high half of every sample period the block expects at least one falling edge of the primary clock. A sample period with no such edge is treated as a dead oscillator. The block then moves the system clock selection onto the internal oscillator, raises a sticky interrupt flag and issues a one-cycle clear pulse to the watchdog and its postscaler, so that they restart their timing at the new, slower execution rate.

After reset, the block keeps the system on the internal oscillator until the start-up timer reports that the primary source is ready. It then hands the clock over and begins monitoring. Once the fail-safe condition has been entered, it holds until device reset or a power-managed-mode entry strobe. During that time the clock-source ready status keeps reporting the primary source, as it did before the failure. All control logic runs on the low-frequency clock. The only logic on the primary clock is a single edge-catching flop, which the sample divider clears asynchronously and which is read back through a two-flop synchroniser.

Top module: `clk_fail_monitor`

## Requirements
- R1: While rst_ni is low and directly after it rises, the outputs are sel_int_o=1, src_ready_o=0, failsafe_o=0, fail_flag_o=0 and wdt_clr_o=0.
- R2: From reset, or after leaving fail-safe, sel_int_o stays 1 and src_ready_o stays 0 until a rising lfclk_i edge samples pri_ready_i=1. From that edge on, sel_int_o=0 and src_ready_o=1.
- R3: While the primary source is selected and mon_en_i=1, a divider phase counts lfclk_i edges modulo 2**DIV_LOG2 and is held at 0 otherwise. A sample period starts at the edge with phase 0 and is checked at the edge with phase 2**(DIV_LOG2-1). A primary falling edge is credited only if it falls after the edge that follows the period start and at least SYNC_STAGES+1 lfclk_i edges before the check edge. A primary clock that runs continuously never causes a failure.
- R4: If no primary falling edge is credited to a sample period, a failure is declared at that period's check edge.
- R5: At the edge where a failure is declared, fail_flag_o=1, failsafe_o=1 and sel_int_o=1. wdt_clr_o is 1 for exactly that one lfclk_i cycle.
- R6: While failsafe_o=1, src_ready_o stays 1.
- R7: failsafe_o stays 1, whatever the primary clock does, until an lfclk_i edge samples pm_entry_i=1 (after that edge the block is back in the R2 start-up wait) or until reset.
- R8: fail_flag_o is sticky. An lfclk_i edge that samples flag_clr_i=1 clears it, unless a failure is declared at that same edge, in which case the flag ends up set.
- R9: While mon_en_i=0, no failure is declared even with the primary clock stopped, and the divider phase restarts from 0 when mon_en_i returns to 1.
- R10: While the internal clock is selected (start-up wait or fail-safe), a stopped primary clock causes no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Primary device clock being monitored |
| lfclk_i | input | 1 | Always-running internal low-frequency clock |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| mon_en_i | input | 1 | Monitoring enable (lfclk_i domain) |
| pri_ready_i | input | 1 | Primary source ready from the start-up timer (lfclk_i domain) |
| pm_entry_i | input | 1 | Power-managed-mode entry strobe (lfclk_i domain) |
| flag_clr_i | input | 1 | Software clear of the failure interrupt flag |
| sel_int_o | output | 1 | Clock mux select: 1 = internal oscillator, 0 = primary |
| fail_flag_o | output | 1 | Sticky oscillator-fail interrupt flag |
| wdt_clr_o | output | 1 | One-cycle clear pulse to watchdog and postscaler |
| failsafe_o | output | 1 | Fail-safe condition active |
| src_ready_o | output | 1 | Clock-source ready status seen by software |

## Verification
The bench builds the block with DIV_LOG2=3 and SYNC_STAGES=2. A sample period is then eight low-frequency cycles, and the credit window shrinks to a single low-frequency cycle, which is the tightest window the parameters allow. This puts dozens of sample periods, and both the start and stop transitions of the primary clock, within a short run. The primary clock toggles on odd nanoseconds and the low-frequency clock on even ones, so the exact check edge of every failure can be predicted from the recorded edge times and compared on each cycle.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_PRI  = 2'd1,
    ST_SAFE = 2'd2
  } mode_e;
endpackage

// File: rtl/cfm_sample_div.sv
module cfm_sample_div #(
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic chk_o,
  output logic clr_o
);
  localparam int unsigned CW   = DIV_LOG2;
  localparam int unsigned HALF = (1 << DIV_LOG2) / 2;

  logic [CW-1:0] cnt_q;
  logic          clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // clear held while idle and for one cycle at each sample-period start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b1;
    else         clr_q <= !run_i || (cnt_q == '0);
  end

  assign chk_o = run_i && (cnt_q == CW'(HALF));
  assign clr_o = clr_q;
endmodule

// File: rtl/cfm_edge_catch.sv
module cfm_edge_catch (
  input  logic pclk_i,
  input  logic clr_i,
  output logic seen_o
);
  logic seen_q;

  always_ff @(negedge pclk_i or posedge clr_i) begin
    if (clr_i) seen_q <= 1'b0;
    else       seen_q <= 1'b1;
  end

  assign seen_o = seen_q;
endmodule

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
  import cfm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic pri_ready_i,
  input  logic pm_entry_i,
  input  logic flag_clr_i,
  input  logic chk_i,
  input  logic seen_i,
  output logic run_o,
  output logic sel_int_o,
  output logic failsafe_o,
  output logic src_ready_o,
  output logic fail_flag_o,
  output logic wdt_clr_o
);
  mode_e mode_q, mode_d;
  logic  flag_q, wdt_q;
  logic  fail_det;

  assign run_o    = mon_en_i && (mode_q == ST_PRI);
  assign fail_det = chk_i && !seen_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      ST_BOOT: if (pri_ready_i) mode_d = ST_PRI;
      ST_PRI:  if (fail_det)    mode_d = ST_SAFE;
      ST_SAFE: if (pm_entry_i)  mode_d = ST_BOOT;
      default: mode_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ST_BOOT;
      flag_q <= 1'b0;
      wdt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wdt_q  <= fail_det;
      if (fail_det)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign sel_int_o   = (mode_q != ST_PRI);
  assign failsafe_o  = (mode_q == ST_SAFE);
  assign src_ready_o = (mode_q != ST_BOOT);
  assign fail_flag_o = flag_q;
  assign wdt_clr_o   = wdt_q;
endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor #(
  parameter int unsigned DIV_LOG2    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic pclk_i,
  input  logic lfclk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic pri_ready_i,
  input  logic pm_entry_i,
  input  logic flag_clr_i,
  output logic sel_int_o,
  output logic fail_flag_o,
  output logic wdt_clr_o,
  output logic failsafe_o,
  output logic src_ready_o
);
  // the check must trail the clear release by more than the synchroniser depth
  localparam int unsigned HALF = (1 << DIV_LOG2) / 2;
  localparam bit WIN_OK = (HALF >= SYNC_STAGES + 2);

  logic run, chk, clr, seen_raw, seen_s;

  initial begin
    if (!WIN_OK) $error("DIV_LOG2 too small for SYNC_STAGES");
  end

  cfm_sample_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i  (lfclk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .chk_o  (chk),
    .clr_o  (clr)
  );

  cfm_edge_catch u_catch (
    .pclk_i (pclk_i),
    .clr_i  (clr),
    .seen_o (seen_raw)
  );

  cfm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (lfclk_i),
    .rst_ni (rst_ni),
    .d_i    (seen_raw),
    .q_o    (seen_s)
  );

  cfm_ctrl u_ctrl (
    .clk_i       (lfclk_i),
    .rst_ni      (rst_ni),
    .mon_en_i    (mon_en_i),
    .pri_ready_i (pri_ready_i),
    .pm_entry_i  (pm_entry_i),
    .flag_clr_i  (flag_clr_i),
    .chk_i       (chk),
    .seen_i      (seen_s),
    .run_o       (run),
    .sel_int_o   (sel_int_o),
    .failsafe_o  (failsafe_o),
    .src_ready_o (src_ready_o),
    .fail_flag_o (fail_flag_o),
    .wdt_clr_o   (wdt_clr_o)
  );
endmodule

// File: rtl/clk_fail_monitor_chk.sv
module clk_fail_monitor_chk (
  input logic lfclk_i,
  input logic rst_ni,
  input logic mon_en_i,
  input logic pm_entry_i,
  input logic flag_clr_i,
  input logic sel_int_o,
  input logic fail_flag_o,
  input logic wdt_clr_o,
  input logic failsafe_o,
  input logic src_ready_o
);
  AST_BOOT_ON_INT: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    !src_ready_o |-> sel_int_o); // R2
  AST_ENTRY_PULSES: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    $rose(failsafe_o) |-> wdt_clr_o); // R4
  AST_PULSE_EFFECTS: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    wdt_clr_o |-> fail_flag_o && failsafe_o && sel_int_o); // R5
  AST_PULSE_SINGLE: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o); // R5
  AST_READY_KEPT: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    failsafe_o |-> src_ready_o && sel_int_o); // R6
  AST_SAFE_HOLDS: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    failsafe_o && !pm_entry_i |=> failsafe_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    fail_flag_o && !flag_clr_i |=> fail_flag_o); // R8
  AST_OFF_QUIET: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    !mon_en_i |=> !wdt_clr_o); // R9
  AST_INT_NO_DETECT: assert property (@(posedge lfclk_i) disable iff (!rst_ni)
    sel_int_o |=> !wdt_clr_o); // R10
endmodule

bind clk_fail_monitor clk_fail_monitor_chk u_chk (
  .lfclk_i     (lfclk_i),
  .rst_ni      (rst_ni),
  .mon_en_i    (mon_en_i),
  .pm_entry_i  (pm_entry_i),
  .flag_clr_i  (flag_clr_i),
  .sel_int_o   (sel_int_o),
  .fail_flag_o (fail_flag_o),
  .wdt_clr_o   (wdt_clr_o),
  .failsafe_o  (failsafe_o),
  .src_ready_o (src_ready_o)
);

// File: tb/clk_fail_monitor_bench.sv
`timescale 1ns/1ps
module clk_fail_monitor_bench;
  localparam int DIV_LOG2 = 3;
  localparam int SYNC     = 2;
  localparam int DIV      = 1 << DIV_LOG2;
  localparam int HALF     = DIV / 2;

  logic lfclk = 1'b0;
  logic pclk  = 1'b1;
  bit   pclk_run = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b1, pri_ready = 1'b0, pm_entry = 1'b0, flag_clr = 1'b0;
  logic sel_int, fail_flag, wdt_clr, failsafe, src_ready;

  int n_run = 0, n_fail = 0, cyc = 0, wdt_cnt = 0;
  bit done = 0;
  string cur_req = "R1";
  bit had_neg[int];

  int m_st, m_ph;
  bit m_flag, m_wdt;

  clk_fail_monitor #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC)) u_clk_fail_monitor (
    .pclk_i (pclk), .lfclk_i (lfclk), .rst_ni (rst_n), .mon_en_i (mon_en),
    .pri_ready_i (pri_ready), .pm_entry_i (pm_entry), .flag_clr_i (flag_clr),
    .sel_int_o (sel_int), .fail_flag_o (fail_flag), .wdt_clr_o (wdt_clr),
    .failsafe_o (failsafe), .src_ready_o (src_ready)
  );

  always #10 lfclk = ~lfclk;              // 50 MHz, edges on even ns
  initial begin
    #1;
    forever begin
      if (pclk_run) pclk = ~pclk;         // edges on odd ns only
      #2;
    end
  end

  always @(negedge pclk) had_neg[cyc] = 1'b1;

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference, evaluated at every lfclk rising edge
  always @(posedge lfclk) begin
    bit active, det, seen;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_flag = 0; m_wdt = 0;
    end else begin
      active = mon_en && (m_st == 1);
      det = 0;
      if (active && m_ph == HALF) begin
        seen = 0;
        for (int i = cyc - HALF + 1; i <= cyc - SYNC - 1; i++)
          if (had_neg.exists(i)) seen = 1;
        det = !seen;
      end
      m_ph  = active ? (m_ph + 1) % DIV : 0;
      m_wdt = det;
      if (det) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      case (m_st)
        0: if (pri_ready) m_st = 1;
        1: if (det) m_st = 2;
        default: if (pm_entry) m_st = 0;
      endcase
    end
  end

  always @(negedge lfclk) begin
    if (!done) begin
      check(cur_req, "sel_int",   sel_int,   m_st != 1);
      check(cur_req, "failsafe",  failsafe,  m_st == 2);
      check(cur_req, "src_ready", src_ready, m_st != 0);
      check(cur_req, "fail_flag", fail_flag, m_flag);
      check(cur_req, "wdt_clr",   wdt_clr,   m_wdt);
      if (wdt_clr) begin
        wdt_cnt++;
        check("R8", "flag at failure edge", fail_flag, 1);
      end
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 20000);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge lfclk);
    #2;
  endtask

  initial begin
    int w0;
    cur_req = "R1";
    step(3);
    check("R1", "reset sel_int", sel_int, 1);
    check("R1", "reset src_ready", src_ready, 0);
    check("R1", "reset flag", fail_flag, 0);
    rst_n = 1'b1;
    step(1);
    check("R1", "post-reset failsafe", failsafe, 0);

    cur_req = "R10";                      // start-up wait with dead primary
    step(40);
    check("R10", "no failure in start-up", failsafe, 0);
    check("R2", "waits on internal", sel_int, 1);

    cur_req = "R2";
    pclk_run = 1'b1;
    pri_ready = 1'b1;
    step(2);
    check("R2", "switched to primary", sel_int, 0);
    check("R2", "ready status", src_ready, 1);

    cur_req = "R3";
    step(100);
    check("R3", "running primary no failure", failsafe, 0);

    cur_req = "R4";
    pclk_run = 1'b0;
    step(3 * DIV);
    check("R4", "stopped primary detected", failsafe, 1);
    check("R5", "flag set", fail_flag, 1);
    check("R5", "one clear pulse", wdt_cnt, 1);
    check("R6", "ready kept", src_ready, 1);

    cur_req = "R7";
    pclk_run = 1'b1;
    step(40);
    check("R7", "failsafe holds with primary back", failsafe, 1);
    check("R7", "still on internal", sel_int, 1);

    cur_req = "R8";
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    step(1);
    check("R8", "flag cleared by write", fail_flag, 0);
    check("R8", "failsafe unaffected", failsafe, 1);

    cur_req = "R7";
    pri_ready = 1'b0;
    pm_entry = 1'b1; step(1); pm_entry = 1'b0;
    step(1);
    check("R7", "left failsafe", failsafe, 0);
    check("R7", "back to start-up", src_ready, 0);
    step(10);
    check("R2", "waits for ready again", sel_int, 1);
    pri_ready = 1'b1;
    step(20);
    check("R2", "primary reselected", sel_int, 0);

    cur_req = "R9";
    mon_en = 1'b0;
    pclk_run = 1'b0;
    step(60);
    check("R9", "no failure while disabled", failsafe, 0);
    check("R9", "flag untouched while disabled", fail_flag, 0);
    cur_req = "R4";
    w0 = wdt_cnt;
    mon_en = 1'b1;
    step(3 * DIV);
    check("R4", "detect after enable", failsafe, 1);
    check("R5", "second pulse", wdt_cnt - w0, 1);

    cur_req = "R8";                       // clear held across a failure
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    check("R1", "reset leaves failsafe", failsafe, 0);
    pclk_run = 1'b1;
    step(30);
    flag_clr = 1'b1;
    pclk_run = 1'b0;
    step(3 * DIV);
    check("R8", "failsafe entered under clear", failsafe, 1);
    check("R8", "flag cleared after set edge", fail_flag, 0);
    flag_clr = 1'b0;

    cur_req = "R1";
    rst_n = 1'b0;
    step(1);
    check("R1", "async reset sel_int", sel_int, 1);
    check("R1", "async reset flag", fail_flag, 0);
    rst_n = 1'b1;
    step(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule